// File: doc/BRIEF.md
# Stream Buffer Allocation Filter and Port Scheduler

This block is the control core of a set of stream buffers. It decides whether a missing load may claim a buffer, which buffer it claims, and which active buffer is served each cycle by the shared address predictor and prefetch port. The buffers themselves, the prediction tables and the memory path lie outside. They report to this block through prediction outcomes, misses, lookup hits and per-buffer request lines.

Allocation has two selectable filters. The confidence filter keeps a saturating accuracy counter for each load-table slot, and lets a miss allocate only when that counter shows the load has been predicting well. The baseline filter allocates on every second miss from the same slot. Each buffer carries a priority counter. It starts at the middle of its range on allocation, climbs on lookup hits and drains on a fixed period. In priority mode the port goes to the requesting active buffer with the highest counter. In round-robin mode the port rotates evenly across requesters.

Top module: `sbuf_alloc_sched`

## Requirements
- R1: After reset no buffer is active, every priority counter reads 0, every accuracy counter is 0, and `grant_valid` stays low even if every request line is high.
- R2: Each load slot's accuracy counter is 2 bits wide. It counts up on `upd_correct`=1 and down on `upd_correct`=0 when `upd_valid` is high. It saturates at 3 and 0. A miss in the same cycle is judged on the value held before that update.
- R3: With `conf_mode`=1, a miss (`miss_valid`) raises `alloc_valid` in the same cycle exactly when the missing slot's accuracy counter is 2 or 3.
- R4: With `conf_mode`=0, each slot has a one-bit pending flag, cleared at reset, that flips on every miss from that slot. A miss allocates exactly when the flag was already set, so allocation happens on every second miss.
- R5: An allocation goes to the lowest-index inactive buffer. When all buffers are active, it goes to the active buffer with the lowest priority, with ties going to the lower index. Once active, a buffer stays active.
- R6: The priority counter of the buffer just allocated reads 8, half of its 4-bit range, on the next cycle. This holds whatever hit or decay happens in that cycle.
- R7: A hit (`hit_valid`, `hit_buf`) on an active buffer raises its priority by 1, saturating at 15. A hit on an inactive buffer changes nothing.
- R8: Every 64th clock after reset (edges 63, 127, ...), every priority counter drops by 1, with a floor of 0. A buffer that gets a hit on a decay edge keeps its value.
- R9: With `prio_mode`=1, only buffers that are both active and requesting compete. The one with the highest priority wins `grant_buf` in the same cycle, and ties go to the lowest index. `grant_valid` is low when none compete.
- R10: With `prio_mode`=0, the winner is the first competing buffer at or after a rotating pointer, wrapping around. The pointer starts at 0 and, after each grant in this mode, moves to one past the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conf_mode | input | 1 | 1: accuracy-gated allocation, 0: second-miss allocation |
| prio_mode | input | 1 | 1: priority scheduling, 0: round-robin |
| upd_valid | input | 1 | Prediction outcome present |
| upd_idx | input | LIDX_W | Load slot of the outcome |
| upd_correct | input | 1 | Outcome was a correct prediction |
| miss_valid | input | 1 | Load miss present, candidate for allocation |
| miss_idx | input | LIDX_W | Load slot of the miss |
| hit_valid | input | 1 | Lookup hit in a buffer |
| hit_buf | input | BIDX_W | Buffer that hit |
| buf_req | input | NUM_BUF | Buffer has an empty entry or pending prefetch |
| alloc_valid | output | 1 | Allocation decided this cycle |
| alloc_buf | output | BIDX_W | Buffer being allocated |
| grant_valid | output | 1 | Port granted this cycle |
| grant_buf | output | BIDX_W | Buffer granted the port |
| buf_active | output | NUM_BUF | Buffers currently allocated |
| buf_pri | output | NUM_BUF*PRI_W | Priority counters, buffer i at bits [i*PRI_W +: PRI_W] |

## Verification
Prediction outcomes are driven for every load slot as a pseudo-random series of correct and wrong results, followed by a miss. This separates the confidence threshold from a wrong saturation point. Miss series over a few slots in baseline mode show whether allocation fires only on alternate misses. A long period of dense hits, followed by a longer period with none, drives the counters to both rails and across many decay edges. Request lines are swept over all sixteen patterns in both scheduling modes, once with saturated counters and once with all counters equal. This separates the ranking rule, the lowest-index tie rule and the rotating pointer.

// File: rtl/sbuf_alloc_sched.sv
module sbuf_alloc_sched #(
  parameter int NUM_BUF      = 4,
  parameter int NUM_LOADS    = 16,
  parameter int ACC_W        = 2,
  parameter int PRI_W        = 4,
  parameter int DECAY_PERIOD = 64,
  localparam int LIDX_W = $clog2(NUM_LOADS),
  localparam int BIDX_W = $clog2(NUM_BUF),
  localparam int DCY_W  = $clog2(DECAY_PERIOD)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     conf_mode,
  input  logic                     prio_mode,
  input  logic                     upd_valid,
  input  logic [LIDX_W-1:0]        upd_idx,
  input  logic                     upd_correct,
  input  logic                     miss_valid,
  input  logic [LIDX_W-1:0]        miss_idx,
  input  logic                     hit_valid,
  input  logic [BIDX_W-1:0]        hit_buf,
  input  logic [NUM_BUF-1:0]       buf_req,
  output logic                     alloc_valid,
  output logic [BIDX_W-1:0]        alloc_buf,
  output logic                     grant_valid,
  output logic [BIDX_W-1:0]        grant_buf,
  output logic [NUM_BUF-1:0]       buf_active,
  output logic [NUM_BUF*PRI_W-1:0] buf_pri
);
  localparam logic [ACC_W-1:0] ACC_MAX  = '1;
  localparam logic [ACC_W-1:0] ACC_GATE = ACC_W'(1 << (ACC_W-1));
  localparam logic [PRI_W-1:0] PRI_MAX  = '1;
  localparam logic [PRI_W-1:0] PRI_MID  = PRI_W'(1 << (PRI_W-1));

  logic [ACC_W-1:0]  acc   [NUM_LOADS];
  logic [NUM_LOADS-1:0] pend;
  logic [PRI_W-1:0]  pri   [NUM_BUF];
  logic [NUM_BUF-1:0] active;
  logic [BIDX_W-1:0] rr_ptr;
  logic [DCY_W-1:0]  dcnt;

  wire decay = dcnt == DCY_W'(DECAY_PERIOD - 1);
  wire [NUM_BUF-1:0] elig = buf_req & active;

  assign buf_active  = active;
  assign alloc_valid = miss_valid && (conf_mode ? (acc[miss_idx] >= ACC_GATE) : pend[miss_idx]);

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_pri_out
    assign buf_pri[g*PRI_W +: PRI_W] = pri[g];
  end

  // victim selection: free slot first, else weakest active buffer
  logic              have_free;
  logic [BIDX_W-1:0] free_idx, weak_idx;
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (!active[i]) begin
        have_free = 1'b1;
        free_idx  = BIDX_W'(i);
      end
    end
    weak_idx = '0;
    for (int i = 1; i < NUM_BUF; i++) begin
      if (pri[i] < pri[weak_idx]) weak_idx = BIDX_W'(i);
    end
  end
  assign alloc_buf = have_free ? free_idx : weak_idx;

  // port arbitration
  logic              pg_found, rg_found;
  logic [BIDX_W-1:0] pg_idx, rg_idx, rr_j;
  always_comb begin
    pg_found = 1'b0;
    pg_idx   = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (elig[i] && (!pg_found || pri[i] > pri[pg_idx])) begin
        pg_found = 1'b1;
        pg_idx   = BIDX_W'(i);
      end
    end
    rg_found = 1'b0;
    rg_idx   = '0;
    rr_j     = '0;
    for (int off = 0; off < NUM_BUF; off++) begin
      rr_j = rr_ptr + BIDX_W'(off);
      if (!rg_found && elig[rr_j]) begin
        rg_found = 1'b1;
        rg_idx   = rr_j;
      end
    end
  end
  assign grant_valid = prio_mode ? pg_found : rg_found;
  assign grant_buf   = prio_mode ? pg_idx : rg_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LOADS; l++) acc[l] <= '0;
      pend   <= '0;
      active <= '0;
      rr_ptr <= '0;
      dcnt   <= '0;
      for (int b = 0; b < NUM_BUF; b++) pri[b] <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
      if (upd_valid) begin
        if (upd_correct && acc[upd_idx] != ACC_MAX) acc[upd_idx] <= acc[upd_idx] + 1'b1;
        if (!upd_correct && acc[upd_idx] != '0)     acc[upd_idx] <= acc[upd_idx] - 1'b1;
      end
      if (miss_valid && !conf_mode) pend[miss_idx] <= !pend[miss_idx];
      if (alloc_valid) active[alloc_buf] <= 1'b1;
      if (!prio_mode && rg_found) rr_ptr <= rg_idx + 1'b1;
      for (int b = 0; b < NUM_BUF; b++) begin
        if (alloc_valid && alloc_buf == BIDX_W'(b)) begin
          pri[b] <= PRI_MID;
        end else if (hit_valid && hit_buf == BIDX_W'(b) && active[b]) begin
          if (!decay && pri[b] != PRI_MAX) pri[b] <= pri[b] + 1'b1;
        end else if (decay && pri[b] != '0) begin
          pri[b] <= pri[b] - 1'b1;
        end
      end
    end
  end
endmodule

module sbuf_alloc_sched_chk #(
  parameter int NUM_BUF = 4,
  parameter int PRI_W   = 4,
  localparam int BIDX_W = $clog2(NUM_BUF)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     prio_mode,
  input logic [NUM_BUF-1:0]       buf_req,
  input logic                     alloc_valid,
  input logic [BIDX_W-1:0]        alloc_buf,
  input logic                     grant_valid,
  input logic [BIDX_W-1:0]        grant_buf,
  input logic [NUM_BUF-1:0]       buf_active,
  input logic [NUM_BUF*PRI_W-1:0] buf_pri
);
  logic              prev_alloc;
  logic [BIDX_W-1:0] prev_buf;
  logic              better;
  logic [PRI_W-1:0]  gpri, prev_pri;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_alloc <= 1'b0;
      prev_buf   <= '0;
    end else begin
      prev_alloc <= alloc_valid;
      prev_buf   <= alloc_buf;
    end
  end

  always_comb begin
    gpri     = buf_pri[grant_buf*PRI_W +: PRI_W];
    prev_pri = buf_pri[prev_buf*PRI_W +: PRI_W];
    better   = 1'b0;
    for (int j = 0; j < NUM_BUF; j++)
      if (buf_req[j] && buf_active[j] && buf_pri[j*PRI_W +: PRI_W] > gpri) better = 1'b1;
  end

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (buf_req[grant_buf] && buf_active[grant_buf])); // R9
  AST_GRANT_IF_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(buf_req & buf_active)) |-> grant_valid); // R9
  AST_PRIO_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_mode && grant_valid) |-> !better); // R9
  AST_ALLOC_MIDPOINT: assert property (@(posedge clk) disable iff (!rst_n)
    prev_alloc |-> prev_pri == PRI_W'(1 << (PRI_W-1))); // R6
  AST_ALLOC_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !(&buf_active)) |-> !buf_active[alloc_buf]); // R5
  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> buf_active[prev_buf]); // R5
endmodule

bind sbuf_alloc_sched sbuf_alloc_sched_chk #(.NUM_BUF(NUM_BUF), .PRI_W(PRI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .buf_req(buf_req),
  .alloc_valid(alloc_valid), .alloc_buf(alloc_buf), .grant_valid(grant_valid),
  .grant_buf(grant_buf), .buf_active(buf_active), .buf_pri(buf_pri));

// File: tb/tb_sbuf_alloc_sched.sv
module tb_sbuf_alloc_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NL = 16;

  logic clk = 0, rst_n = 0;
  logic conf_mode = 1, prio_mode = 1;
  logic upd_valid = 0, upd_correct = 0, miss_valid = 0, hit_valid = 0;
  logic [3:0] upd_idx = 0, miss_idx = 0;
  logic [1:0] hit_buf = 0;
  logic [NB-1:0] buf_req = 0;
  logic alloc_valid, grant_valid;
  logic [1:0] alloc_buf, grant_buf;
  logic [NB-1:0] buf_active;
  logic [NB*4-1:0] buf_pri;

  sbuf_alloc_sched dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int m_acc[NL];
  int m_pend[NL];
  int m_act[NB];
  int m_pri[NB];
  int m_rr = 0;
  int k = 0;
  logic [15:0] lf = 16'hACE1;
  string tg_alloc = "R3", tg_pri = "R7";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void lstep();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  task automatic step();
    int ea, eb, eg, gb, best;
    int act_mask;
    #1;
    ea = 0;
    if (miss_valid) ea = conf_mode ? (m_acc[miss_idx] >= 2) : m_pend[miss_idx];
    eb = -1;
    for (int i = NB - 1; i >= 0; i--) if (!m_act[i]) eb = i;
    if (eb < 0) begin
      eb = 0;
      for (int i = 1; i < NB; i++) if (m_pri[i] < m_pri[eb]) eb = i;
    end
    eg = 0; gb = 0; best = -1;
    if (prio_mode) begin
      for (int i = 0; i < NB; i++)
        if (buf_req[i] && m_act[i] && m_pri[i] > best) begin eg = 1; gb = i; best = m_pri[i]; end
    end else begin
      for (int o = 0; o < NB; o++) begin
        int j = (m_rr + o) % NB;
        if (!eg && buf_req[j] && m_act[j]) begin eg = 1; gb = j; end
      end
    end
    act_mask = 0;
    for (int i = 0; i < NB; i++) act_mask |= m_act[i] << i;
    chk(alloc_valid == ea[0], tg_alloc, alloc_valid, ea);
    if (ea != 0) chk(alloc_buf == eb[1:0], "R5", alloc_buf, eb);
    chk(grant_valid == eg[0], prio_mode ? "R9" : "R10", grant_valid, eg);
    if (eg != 0) chk(grant_buf == gb[1:0], prio_mode ? "R9" : "R10", grant_buf, gb);
    chk(buf_active == act_mask[NB-1:0], "R5", buf_active, act_mask);
    for (int i = 0; i < NB; i++)
      chk(buf_pri[i*4 +: 4] == m_pri[i][3:0], tg_pri, buf_pri[i*4 +: 4], m_pri[i]);
    @(posedge clk);
    if (upd_valid) begin
      if (upd_correct && m_acc[upd_idx] < 3) m_acc[upd_idx]++;
      if (!upd_correct && m_acc[upd_idx] > 0) m_acc[upd_idx]--;
    end
    if (miss_valid && !conf_mode) m_pend[miss_idx] = 1 - m_pend[miss_idx];
    for (int i = 0; i < NB; i++) begin
      bit dec = (k % 64) == 63;
      if (ea != 0 && eb == i) m_pri[i] = 8;
      else if (hit_valid && hit_buf == i && m_act[i]) begin
        if (!dec && m_pri[i] < 15) m_pri[i]++;
      end else if (dec && m_pri[i] > 0) m_pri[i]--;
    end
    if (ea != 0) m_act[eb] = 1;
    if (!prio_mode && eg != 0) m_rr = (gb + 1) % NB;
    k++;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_acc[i] = 0; m_pend[i] = 0; end
    for (int i = 0; i < NB; i++) begin m_act[i] = 0; m_pri[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, all requests raised, nothing granted
    buf_req = '1;
    #1;
    chk(buf_active == 0, "R1", buf_active, 0);
    chk(buf_pri == 0, "R1", buf_pri, 0);
    chk(grant_valid == 0, "R1", grant_valid, 0);
    // R7: hits to inactive buffers are ignored
    tg_pri = "R7";
    for (int i = 0; i < 4; i++) begin hit_valid = 1; hit_buf = i[1:0]; step(); end
    hit_valid = 0;
    // R1: no slot can allocate from reset in confidence mode
    tg_alloc = "R1";
    for (int i = 0; i < NL; i++) begin miss_valid = 1; miss_idx = i[3:0]; step(); end
    miss_valid = 0;
    // R2/R3: outcome series per slot, then a miss judged on the counter
    tg_alloc = "R2/R3"; tg_pri = "R6";
    for (int i = 0; i < NL; i++) begin
      for (int u = 0; u < 6; u++) begin
        upd_valid = 1; upd_idx = i[3:0]; upd_correct = lf[0] | lf[3]; lstep(); step();
      end
      upd_valid = 0; miss_valid = 1; miss_idx = i[3:0]; step();
      miss_valid = 0;
    end
    // R2: update and miss on the same slot in the same cycle
    for (int i = 0; i < 40; i++) begin
      upd_valid = lf[1]; upd_idx = {2'b00, lf[5:4]}; upd_correct = lf[2];
      miss_valid = lf[6]; miss_idx = {2'b00, lf[5:4]}; buf_req = lf[11:8];
      lstep(); step();
    end
    upd_valid = 0;
    // R4: second-miss filter
    conf_mode = 0; tg_alloc = "R4";
    for (int i = 0; i < 60; i++) begin
      miss_valid = lf[0] | lf[7]; miss_idx = {2'b00, lf[3:2]}; buf_req = lf[11:8];
      lstep(); step();
    end
    miss_valid = 0; conf_mode = 1;
    // R7/R8: dense hits to saturation, then pure decay to the floor
    tg_pri = "R7/R8";
    for (int i = 0; i < 400; i++) begin
      hit_valid = lf[0] | lf[5]; hit_buf = lf[3:2]; buf_req = lf[11:8];
      prio_mode = (i / 100) % 2 == 0;
      lstep(); step();
    end
    // R9/R10: exhaustive request sweep with saturated, unequal counters
    hit_valid = 0;
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 16; r++) begin prio_mode = m[0]; buf_req = r[3:0]; step(); end
    tg_pri = "R8";
    for (int i = 0; i < 1100; i++) begin
      buf_req = lf[11:8]; prio_mode = lf[12]; lstep(); step();
    end
    // R9/R10: sweep again with all counters at 0 (tie rule, pointer)
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 16; r++) begin prio_mode = m[0]; buf_req = r[3:0]; step(); end
    // R5/R6: replacement of the weakest buffer once all are active
    tg_pri = "R6"; prio_mode = 1;
    for (int l = 0; l < 4; l++) begin
      repeat (2) begin upd_valid = 1; upd_idx = 4'(l + 8); upd_correct = 1; step(); end
    end
    upd_valid = 0;
    for (int i = 0; i < 24; i++) begin
      hit_valid = lf[0]; hit_buf = lf[2:1]; miss_valid = lf[4]; miss_idx = 4'(8 + (i % 4));
      buf_req = lf[11:8]; lstep(); step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule